// File: doc/BRIEF.md
# Mixed-Edge Scan Chain with Domain Lockup

This block is a mux-D scan chain built from single-bit functional registers. The registers fall into three groups. One group captures on the falling edge of clock A. One captures on the rising edge of clock A. The third captures on the rising edge of clock B. In functional mode each register loads its own data input. In shift mode the registers form one serial path from `scan_in` to `scan_out`.

The path is ordered so that every shift period moves each bit forward by exactly one position. The falling-edge group comes first, at the `scan_in` end. The rising-edge group of clock A follows it. A lockup latch comes next, then the clock B group, whose last cell drives `scan_out`. Clock A idles low, so within a period its rising edge comes before its falling edge. A rising-edge stage feeding a falling-edge stage would pass one bit through both stages in the same period, and the ordering never creates that link. The latch is open while clock A is low, so it holds the launched bit through the high phase of clock A. This gives clock B hold margin against skew.

A capture works as follows. Hold `scan_enable` low across one falling edge, the next rising edge and the falling edge after it. This loads every register from its data input. Then raise `scan_enable` and shift the chain out.

Top module: `mixed_edge_scan_chain`

## Requirements
- R1: While `rst_n` is low, every register and the lockup latch read 0, so `scan_out` and all register outputs are 0, whatever the data and scan inputs are.
- R2: With `scan_enable` high, each register loads the chain element before it and ignores its functional data input.
- R3: The falling-edge group holds chain positions 0 to FALL_CELLS-1, with position 0 fed from `scan_in`. It shifts on the falling edge of `clk_a`.
- R4: The clock A rising-edge group holds the next RISE_A_CELLS positions. Its first cell loads the last falling-edge cell on the rising edge of `clk_a`.
- R5: The lockup latch sits between the last clock A cell and the first clock B cell. It is transparent while `clk_a` is low and holds while `clk_a` is high, so a `clk_b` edge lagging `clk_a` still takes the bit of the previous period.
- R6: The clock B group holds the last RISE_B_CELLS positions, and `scan_out` is the last cell of the chain.
- R7: Let CHAIN_LEN be the total cell count. A bit placed on `scan_in` after a rising edge of `clk_a` appears on `scan_out` after the rising edge of `clk_b` that comes CHAIN_LEN-1 periods later. Bits come out in order, with none skipped and none repeated.
- R8: With `scan_enable` low, each register loads its functional data input at its own edge, and `scan_in` has no effect.
- R9: After a capture, `scan_out` first shows position CHAIN_LEN-1. Each following shift period then shows the next lower position, down to position 0 (the first falling-edge cell).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of the falling-edge group and the clock A rising-edge group, idles low |
| clk_b | input | 1 | Clock of the clock B rising-edge group |
| rst_n | input | 1 | Asynchronous active-low reset of all cells and the latch |
| scan_enable | input | 1 | 1 = shift along the chain, 0 = load functional data |
| scan_in | input | 1 | Serial input to chain position 0 |
| fall_d | input | FALL_CELLS | Functional data for the falling-edge group |
| rise_a_d | input | RISE_A_CELLS | Functional data for the clock A rising-edge group |
| rise_b_d | input | RISE_B_CELLS | Functional data for the clock B group |
| fall_q | output | FALL_CELLS | Falling-edge group register outputs |
| rise_a_q | output | RISE_A_CELLS | Clock A rising-edge group register outputs |
| rise_b_q | output | RISE_B_CELLS | Clock B group register outputs |
| scan_out | output | 1 | Serial output, the last chain position |

## Verification
`clk_b` runs 2 ns behind `clk_a`, so a chain with no lockup latch, or a latch with the wrong phase, would let clock B take a bit one period early. The bench shifts several patterns and checks every register position in every period, not just `scan_out`:
- An all-ones stream shows that the chain carries data at all.
- An alternating stream separates a half-period slip from a one-period slip.
- A single walking one shows at once any skipped or repeated position.
- Random streams cover the remaining combinations.

Capture runs use random and all-ones data, with `scan_in` set to the opposite of the first data bit so that a leak from the scan path shows up. While the chain unloads, the data inputs are inverted, which exposes a mux that stays open to functional data.

// File: rtl/mescan_pkg.sv
`timescale 1ns/1ps
package mescan_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   function automatic int chain_cells(input int f, input int a, input int b);
      return f + a + b;
   endfunction

endpackage

// File: rtl/mescan_cell.sv
`timescale 1ns/1ps
module mescan_cell
   import mescan_pkg::*;
#(
   parameter edge_kind_e EDGE    = EDGE_RISE,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic shift_in,
   input  logic func_d,
   output logic q
);

   logic nxt;

   // mux-D: serial neighbour in shift mode, own data otherwise
   assign nxt = shift_en ? shift_in : func_d;

   generate
      if (EDGE == EDGE_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= nxt;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/mescan_segment.sv
`timescale 1ns/1ps
module mescan_segment
   import mescan_pkg::*;
#(
   parameter int         CELLS = 4,
   parameter edge_kind_e EDGE  = EDGE_RISE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             seg_in,
   input  logic [CELLS-1:0] func_d,
   output logic [CELLS-1:0] cell_q,
   output logic             seg_out
);

   localparam int LINKS = CELLS + 1;

   logic [LINKS-1:0] link;

   assign link[0]         = seg_in;
   assign link[LINKS-1:1] = cell_q;
   assign seg_out         = link[LINKS-1];

   generate
      if (CELLS < 1) begin : g_bad_cells
         $error("mescan_segment: CELLS must be at least 1");
      end
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         mescan_cell #(
            .EDGE    (EDGE),
            .RST_VAL (1'b0)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .shift_in (link[i]),
            .func_d   (func_d[i]),
            .q        (cell_q[i])
         );
      end
   endgenerate

endmodule

// File: rtl/mescan_lockup.sv
`timescale 1ns/1ps
module mescan_lockup
   import mescan_pkg::*;
#(
   parameter edge_kind_e LAUNCH_EDGE = EDGE_RISE
) (
   input  logic clk_launch,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   // Open during the phase after the launch edge has settled, closed
   // during the phase in which the launching stage may change.
   generate
      if (LAUNCH_EDGE == EDGE_RISE) begin : g_open_low
         always_latch begin
            if (!rst_n)          q <= 1'b0;
            else if (!clk_launch) q <= d;
         end
      end else begin : g_open_high
         always_latch begin
            if (!rst_n)          q <= 1'b0;
            else if (clk_launch) q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/mixed_edge_scan_chain.sv
`timescale 1ns/1ps
module mixed_edge_scan_chain
   import mescan_pkg::*;
#(
   parameter int FALL_CELLS   = 3,
   parameter int RISE_A_CELLS = 4,
   parameter int RISE_B_CELLS = 3
) (
   input  logic                    clk_a,
   input  logic                    clk_b,
   input  logic                    rst_n,
   input  logic                    scan_enable,
   input  logic                    scan_in,
   input  logic [FALL_CELLS-1:0]   fall_d,
   input  logic [RISE_A_CELLS-1:0] rise_a_d,
   input  logic [RISE_B_CELLS-1:0] rise_b_d,
   output logic [FALL_CELLS-1:0]   fall_q,
   output logic [RISE_A_CELLS-1:0] rise_a_q,
   output logic [RISE_B_CELLS-1:0] rise_b_q,
   output logic                    scan_out
);

   localparam int CHAIN_LEN = chain_cells(FALL_CELLS, RISE_A_CELLS, RISE_B_CELLS);

   generate
      if (FALL_CELLS < 1) begin : g_bad_fall
         $error("mixed_edge_scan_chain: FALL_CELLS must be at least 1");
      end
      if (RISE_A_CELLS < 1) begin : g_bad_rise_a
         $error("mixed_edge_scan_chain: RISE_A_CELLS must be at least 1");
      end
      if (RISE_B_CELLS < 1) begin : g_bad_rise_b
         $error("mixed_edge_scan_chain: RISE_B_CELLS must be at least 1");
      end
      if (CHAIN_LEN < 3) begin : g_bad_len
         $error("mixed_edge_scan_chain: chain too short");
      end
   endgenerate

   logic fall_so;
   logic rise_a_so;
   logic lock_q;
   logic rise_b_so;

   // Falling-edge group first: its bit waits half a period for clk_a rise.
   mescan_segment #(
      .CELLS (FALL_CELLS),
      .EDGE  (EDGE_FALL)
   ) u_fall_seg (
      .clk      (clk_a),
      .rst_n    (rst_n),
      .shift_en (scan_enable),
      .seg_in   (scan_in),
      .func_d   (fall_d),
      .cell_q   (fall_q),
      .seg_out  (fall_so)
   );

   mescan_segment #(
      .CELLS (RISE_A_CELLS),
      .EDGE  (EDGE_RISE)
   ) u_rise_a_seg (
      .clk      (clk_a),
      .rst_n    (rst_n),
      .shift_en (scan_enable),
      .seg_in   (fall_so),
      .func_d   (rise_a_d),
      .cell_q   (rise_a_q),
      .seg_out  (rise_a_so)
   );

   // Domain crossing A -> B: hold the launched bit through clk_a high.
   mescan_lockup #(
      .LAUNCH_EDGE (EDGE_RISE)
   ) u_lockup (
      .clk_launch (clk_a),
      .rst_n      (rst_n),
      .d          (rise_a_so),
      .q          (lock_q)
   );

   mescan_segment #(
      .CELLS (RISE_B_CELLS),
      .EDGE  (EDGE_RISE)
   ) u_rise_b_seg (
      .clk      (clk_b),
      .rst_n    (rst_n),
      .shift_en (scan_enable),
      .seg_in   (lock_q),
      .func_d   (rise_b_d),
      .cell_q   (rise_b_q),
      .seg_out  (rise_b_so)
   );

   assign scan_out = rise_b_so;

endmodule

// File: rtl/mixed_edge_scan_chain_chk.sv
`timescale 1ns/1ps
module mixed_edge_scan_chain_chk #(
   parameter int FALL_CELLS   = 3,
   parameter int RISE_A_CELLS = 4,
   parameter int RISE_B_CELLS = 3
) (
   input logic                    clk_a,
   input logic                    clk_b,
   input logic                    rst_n,
   input logic                    scan_enable,
   input logic                    scan_in,
   input logic [FALL_CELLS-1:0]   fall_d,
   input logic [RISE_A_CELLS-1:0] rise_a_d,
   input logic [RISE_B_CELLS-1:0] rise_b_d,
   input logic [FALL_CELLS-1:0]   fall_q,
   input logic [RISE_A_CELLS-1:0] rise_a_q,
   input logic [RISE_B_CELLS-1:0] rise_b_q,
   input logic                    lock_q
);

   AST_FALL_HEAD_SHIFT: assert property (@(negedge clk_a) disable iff (!rst_n)
      scan_enable |=> fall_q[0] == $past(scan_in)); // R3

   generate
      for (genvar j = 1; j < FALL_CELLS; j++) begin : g_fall_body
         AST_FALL_BODY_SHIFT: assert property (@(negedge clk_a) disable iff (!rst_n)
            scan_enable |=> fall_q[j] == $past(fall_q[j-1])); // R3
      end
      for (genvar j = 1; j < RISE_A_CELLS; j++) begin : g_rise_a_body
         AST_RISE_A_BODY_SHIFT: assert property (@(posedge clk_a) disable iff (!rst_n)
            scan_enable |=> rise_a_q[j] == $past(rise_a_q[j-1])); // R4
      end
      for (genvar j = 1; j < RISE_B_CELLS; j++) begin : g_rise_b_body
         AST_RISE_B_BODY_SHIFT: assert property (@(posedge clk_b) disable iff (!rst_n)
            scan_enable |=> rise_b_q[j] == $past(rise_b_q[j-1])); // R6
      end
   endgenerate

   AST_RISE_A_HEAD_SHIFT: assert property (@(posedge clk_a) disable iff (!rst_n)
      scan_enable |=> rise_a_q[0] == $past(fall_q[FALL_CELLS-1])); // R4

   AST_LOCKUP_OPEN_LOW: assert property (@(posedge clk_a) disable iff (!rst_n)
      lock_q == rise_a_q[RISE_A_CELLS-1]); // R5

   AST_RISE_B_HEAD_SHIFT: assert property (@(posedge clk_b) disable iff (!rst_n)
      scan_enable |=> rise_b_q[0] == $past(lock_q)); // R5

   AST_FALL_CAPTURE: assert property (@(negedge clk_a) disable iff (!rst_n)
      !scan_enable |=> fall_q == $past(fall_d)); // R8

   AST_RISE_A_CAPTURE: assert property (@(posedge clk_a) disable iff (!rst_n)
      !scan_enable |=> rise_a_q == $past(rise_a_d)); // R8

   AST_RISE_B_CAPTURE: assert property (@(posedge clk_b) disable iff (!rst_n)
      !scan_enable |=> rise_b_q == $past(rise_b_d)); // R8

endmodule

bind mixed_edge_scan_chain mixed_edge_scan_chain_chk #(
   .FALL_CELLS   (FALL_CELLS),
   .RISE_A_CELLS (RISE_A_CELLS),
   .RISE_B_CELLS (RISE_B_CELLS)
) u_chk (
   .clk_a       (clk_a),
   .clk_b       (clk_b),
   .rst_n       (rst_n),
   .scan_enable (scan_enable),
   .scan_in     (scan_in),
   .fall_d      (fall_d),
   .rise_a_d    (rise_a_d),
   .rise_b_d    (rise_b_d),
   .fall_q      (fall_q),
   .rise_a_q    (rise_a_q),
   .rise_b_q    (rise_b_q),
   .lock_q      (lock_q)
);

// File: tb/mixed_edge_scan_chain_test.sv
`timescale 1ns/1ps
module mixed_edge_scan_chain_test;

   localparam int NF   = 3;
   localparam int NA   = 4;
   localparam int NB   = 3;
   localparam int NL   = NF + NA + NB;
   localparam int PATN = 2 * NL;

   logic          clk_a = 1'b0;
   logic          clk_b = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_enable = 1'b0;
   logic          scan_in = 1'b0;
   logic [NF-1:0] fall_d = '0;
   logic [NA-1:0] rise_a_d = '0;
   logic [NB-1:0] rise_b_d = '0;
   logic [NF-1:0] fall_q;
   logic [NA-1:0] rise_a_q;
   logic [NB-1:0] rise_b_q;
   logic          scan_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic pat [0:PATN-1];

   mixed_edge_scan_chain #(
      .FALL_CELLS   (NF),
      .RISE_A_CELLS (NA),
      .RISE_B_CELLS (NB)
   ) uut (
      .clk_a       (clk_a),
      .clk_b       (clk_b),
      .rst_n       (rst_n),
      .scan_enable (scan_enable),
      .scan_in     (scan_in),
      .fall_d      (fall_d),
      .rise_a_d    (rise_a_d),
      .rise_b_d    (rise_b_d),
      .fall_q      (fall_q),
      .rise_a_q    (rise_a_q),
      .rise_b_q    (rise_b_q),
      .scan_out    (scan_out)
   );

   // 50 MHz; clk_b lags clk_a by 2 ns
   initial forever #10 clk_a = ~clk_a;
   initial begin
      #2;
      forever #10 clk_b = ~clk_b;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // 5 ns after a clk_a rise: both rising groups have settled
   task automatic tick();
      @(posedge clk_a);
      #5;
   endtask

   function automatic logic pat_at(input int k);
      if (k < 0 || k >= PATN) return 1'b0;
      return pat[k];
   endfunction

   // chain position p of a captured vector
   function automatic logic cap_bit(input int p, input logic [NF-1:0] f,
                                    input logic [NA-1:0] a, input logic [NB-1:0] b);
      if (p < NF)      return f[p];
      if (p < NF + NA) return a[p-NF];
      return b[p-NF-NA];
   endfunction

   task automatic run_shift(input string name);
      logic [NF-1:0] ef;
      logic [NA-1:0] ea;
      logic [NB-1:0] eb;
      scan_enable = 1'b1;
      for (int r = 0; r < PATN + NL - 1; r++) begin
         tick();
         if (r >= NL) begin
            // falling group has not yet shifted in this period
            for (int i = 0; i < NF; i++) ef[i] = pat_at(r - 1 - i);
            for (int j = 0; j < NA; j++) ea[j] = pat_at(r - NF - j);
            for (int k = 0; k < NB; k++) eb[k] = pat_at(r - NF - NA - k);
            chk("R3", {name, " fall_q"},   32'(fall_q),   32'(ef));
            chk("R4", {name, " rise_a_q"}, 32'(rise_a_q), 32'(ea));
            chk("R5", {name, " rise_b_q"}, 32'(rise_b_q), 32'(eb));
         end
         if (r >= NL - 1)
            chk("R7", {name, " scan_out"}, 32'(scan_out), 32'(pat_at(r - NL + 1)));
         scan_in = pat_at(r);
      end
   endtask

   task automatic run_capture(input logic [NF-1:0] f, input logic [NA-1:0] a,
                              input logic [NB-1:0] b);
      tick();
      fall_d = f;
      rise_a_d = a;
      rise_b_d = b;
      scan_enable = 1'b0;
      scan_in = ~f[0];
      tick();
      chk("R8", "capture fall_q",   32'(fall_q),   32'(f));
      chk("R8", "capture rise_a_q", 32'(rise_a_q), 32'(a));
      chk("R8", "capture rise_b_q", 32'(rise_b_q), 32'(b));
      chk("R6", "scan_out last cell", 32'(scan_out), 32'(b[NB-1]));
      // keep scan_enable low over the next falling edge, then shift
      @(negedge clk_a);
      #3;
      scan_enable = 1'b1;
      scan_in = 1'b0;
      fall_d = ~f;
      rise_a_d = ~a;
      rise_b_d = ~b;
      for (int t = 1; t < NL; t++) begin
         tick();
         chk("R9 R2", "unload scan_out", 32'(scan_out), 32'(cap_bit(NL - 1 - t, f, a, b)));
      end
   endtask

   initial begin
      #(20 * 50000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240613));
      // R1: reset holds everything at 0 despite active inputs
      fall_d = '1;
      rise_a_d = '1;
      rise_b_d = '1;
      scan_in = 1'b1;
      repeat (3) tick();
      chk("R1", "reset fall_q",   32'(fall_q),   32'd0);
      chk("R1", "reset rise_a_q", 32'(rise_a_q), 32'd0);
      chk("R1", "reset rise_b_q", 32'(rise_b_q), 32'd0);
      chk("R1", "reset scan_out", 32'(scan_out), 32'd0);
      rst_n = 1'b1;
      scan_in = 1'b0;

      for (int k = 0; k < PATN; k++) pat[k] = 1'b1;
      run_shift("ones");
      for (int k = 0; k < PATN; k++) pat[k] = logic'(k % 2);
      run_shift("alternate");
      for (int k = 0; k < PATN; k++) pat[k] = (k == 5);
      run_shift("walking");
      for (int n = 0; n < 3; n++) begin
         for (int k = 0; k < PATN; k++) pat[k] = logic'($urandom() & 1);
         run_shift("random");
      end

      run_capture('1, '1, '1);
      run_capture(3'b010, 4'b1001, 3'b100);
      for (int n = 0; n < 6; n++)
         run_capture(NF'($urandom()), NA'($urandom()), NB'($urandom()));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule